// File: doc/BRIEF.md
# Configuration Extension Bridge

This block sits between the configuration request path of a PCIe function and a user-side extension port. Each configuration access carries a function number, a flag that tells a physical function from a virtual one, a dword register address, byte enables and write data. The bridge checks the address against the windows that the internal register set implements. A hit is served by a small internal register stub. A miss is passed to the extension port as a one-cycle request strobe.

The extension side answers reads with a single-cycle response that carries 32-bit data. Writes on the extension port get no answer. Only one forwarded read may be in flight. While it waits, further reads are held off, but writes still pass. A counter with a compile-time limit guards each forwarded read. If the limit expires, the read completes successfully with zero data, and any response that arrives later is dropped. Each read, internal or forwarded, produces exactly one completion pulse on `cpl_valid`. A pulse always means Successful Completion status.

Top module: `cfg_ext_bridge`

## Requirements
- R1: While reset is held and after it is released, `cpl_valid` and `ext_req` are low and `req_ready` is high.
- R2: A request is internal when its byte offset (dword address times 4) is below the legacy limit, or is at least 0x100 and below the extended limit. An internal read drives `cpl_valid` high for one cycle after the accepting clock edge and does not raise `ext_req`. Its data is `{16'hC0DE, 5'b0, is_vf, dword address}` unless R5 applies.
- R3: A request that is not internal drives `ext_req` for one cycle after the accepting edge. The strobe carries the request's dword address, function number, VF flag, write flag, byte enables and write data unchanged.
- R4: Physical and virtual functions use separate legacy limits (defaults 0x80 and 0x60) and separate extended limits (defaults 0x180 and 0x140). The same offset can therefore be internal for one function type and forwarded for the other.
- R5: The last internal legacy capability (default offset 0x70 for PF, 0x50 for VF) reads `{16'h0000, LEG_NEXT_PTR, 8'h10}`. The last internal extended capability (default 0x160 for PF, 0x120 for VF) reads `{EXT_NEXT_PTR, 4'h1, 16'h0010}`. These values chain host software into the external capabilities.
- R6: For a forwarded read, the clock edge that samples `ext_rsp_valid` produces a completion one cycle later, carrying `ext_rsp_data` unchanged. This includes the all-zero data the extension side returns for space it does not implement.
- R7: While a forwarded read is outstanding, `req_ready` is low for reads and high for writes. A forwarded write accepted in that time still issues its `ext_req`.
- R8: If no response comes, the completion appears `TIMEOUT` cycles after the `ext_req` pulse, with all-zero data.
- R9: A response that arrives after a timeout, or while no forwarded read is outstanding, produces no completion.
- R10: Writes never produce a completion. An internal write also raises no `ext_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_vf | input | 1 | 1 = virtual function, 0 = physical function |
| req_func | input | FUNC_W | Function number |
| req_addr | input | 10 | Dword register address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | One-cycle successful read completion |
| cpl_data | output | 32 | Completion data |
| ext_req | output | 1 | One-cycle extension request strobe |
| ext_write | output | 1 | Extension request is a write |
| ext_is_vf | output | 1 | Extension request VF flag |
| ext_func | output | FUNC_W | Extension request function number |
| ext_addr | output | 10 | Extension request dword address |
| ext_be | output | 4 | Extension request byte enables |
| ext_wdata | output | 32 | Extension request write data |
| ext_rsp_valid | input | 1 | One-cycle read response from extension side |
| ext_rsp_data | input | 32 | Read response data |

## Verification
The bench builds the bridge with `TIMEOUT` set to 12 and keeps the default windows. With that limit, a stalled read, its expiry and a late response all fit in a few dozen cycles, and the bench measures the expiry to the exact cycle. The default limits differ between PF and VF. The bench can therefore probe the same offsets, such as 0x7C and 0x144, as a hit for one function type and a miss for the other. It also reads both next-pointer dwords for each type.

// File: rtl/cfg_ext_bridge.sv
module cfg_ext_bridge #(
  parameter int          FUNC_W       = 3,
  parameter int          TIMEOUT      = 64,
  parameter logic [11:0] PF_LEG_END   = 12'h080,
  parameter logic [11:0] VF_LEG_END   = 12'h060,
  parameter logic [11:0] PF_EXT_END   = 12'h180,
  parameter logic [11:0] VF_EXT_END   = 12'h140,
  parameter logic [11:0] PF_LEG_LAST  = 12'h070,
  parameter logic [11:0] VF_LEG_LAST  = 12'h050,
  parameter logic [11:0] PF_EXT_LAST  = 12'h160,
  parameter logic [11:0] VF_EXT_LAST  = 12'h120,
  parameter logic [7:0]  LEG_NEXT_PTR = 8'hC0,
  parameter logic [11:0] EXT_NEXT_PTR = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_is_vf,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [9:0]        req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              cpl_valid,
  output logic [31:0]       cpl_data,
  output logic              ext_req,
  output logic              ext_write,
  output logic              ext_is_vf,
  output logic [FUNC_W-1:0] ext_func,
  output logic [9:0]        ext_addr,
  output logic [3:0]        ext_be,
  output logic [31:0]       ext_wdata,
  input  logic              ext_rsp_valid,
  input  logic [31:0]       ext_rsp_data
);
  localparam int          TMR_W    = $clog2(TIMEOUT + 1);
  localparam logic [11:0] EXT_BASE = 12'h100;

  logic             rd_busy;
  logic [TMR_W-1:0] tmr;
  logic [31:0]      stub;

  wire [11:0] req_byte = {req_addr, 2'b00};
  wire [11:0] leg_end  = req_is_vf ? VF_LEG_END  : PF_LEG_END;
  wire [11:0] ext_end  = req_is_vf ? VF_EXT_END  : PF_EXT_END;
  wire [11:0] leg_last = req_is_vf ? VF_LEG_LAST : PF_LEG_LAST;
  wire [11:0] ext_last = req_is_vf ? VF_EXT_LAST : PF_EXT_LAST;
  wire        hit      = (req_byte < leg_end) || (req_byte >= EXT_BASE && req_byte < ext_end);

  assign req_ready = !rd_busy || req_write;
  wire   accept    = req_valid && req_ready;
  wire   tmr_done  = (tmr == TMR_W'(TIMEOUT - 1));

  always_comb begin
    if (req_byte == leg_last)      stub = {16'h0000, LEG_NEXT_PTR, 8'h10};
    else if (req_byte == ext_last) stub = {EXT_NEXT_PTR, 4'h1, 16'h0010};
    else                           stub = {16'hC0DE, 5'b0, req_is_vf, req_addr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy   <= 1'b0;
      tmr       <= '0;
      cpl_valid <= 1'b0;
      cpl_data  <= '0;
      ext_req   <= 1'b0;
      ext_write <= 1'b0;
      ext_is_vf <= 1'b0;
      ext_func  <= '0;
      ext_addr  <= '0;
      ext_be    <= '0;
      ext_wdata <= '0;
    end else begin
      cpl_valid <= 1'b0;
      ext_req   <= 1'b0;
      if (accept && hit && !req_write) begin
        cpl_valid <= 1'b1;
        cpl_data  <= stub;
      end
      if (accept && !hit) begin
        ext_req   <= 1'b1;
        ext_write <= req_write;
        ext_is_vf <= req_is_vf;
        ext_func  <= req_func;
        ext_addr  <= req_addr;
        ext_be    <= req_be;
        ext_wdata <= req_wdata;
        if (!req_write) begin
          rd_busy <= 1'b1;
          tmr     <= '0;
        end
      end
      if (rd_busy) begin
        if (ext_rsp_valid) begin
          rd_busy   <= 1'b0;
          cpl_valid <= 1'b1;
          cpl_data  <= ext_rsp_data;
        end else if (tmr_done) begin
          rd_busy   <= 1'b0;
          cpl_valid <= 1'b1;
          cpl_data  <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_ext_bridge_chk.sv
module cfg_ext_bridge_chk #(
  parameter int          TIMEOUT    = 64,
  parameter logic [11:0] PF_LEG_END = 12'h080,
  parameter logic [11:0] VF_LEG_END = 12'h060,
  parameter logic [11:0] PF_EXT_END = 12'h180,
  parameter logic [11:0] VF_EXT_END = 12'h140
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       cpl_valid,
  input logic       ext_req,
  input logic       ext_write,
  input logic       ext_is_vf,
  input logic [9:0] ext_addr,
  input logic       ext_rsp_valid
);
  logic pend;
  int   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= 0;
    end else if (ext_req && !ext_write) begin
      pend <= 1'b1;
      cnt  <= 0;
    end else if (cpl_valid) begin
      pend <= 1'b0;
    end else if (pend) begin
      cnt <= cnt + 1;
    end
  end

  wire [11:0] eb     = {ext_addr, 2'b00};
  wire        ext_in = (eb < (ext_is_vf ? VF_LEG_END : PF_LEG_END)) ||
                       (eb >= 12'h100 && eb < (ext_is_vf ? VF_EXT_END : PF_EXT_END));
  wire        rd_acc = req_valid && req_ready && !req_write;

  // R3
  fwd_only_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !ext_in);
  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_write) |-> !pend);
  // R7
  read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cpl_valid) |-> !rd_acc);
  // R8
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (cnt < TIMEOUT));
  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(ext_req && !ext_write) && ext_rsp_valid && !rd_acc) |=> !cpl_valid);
endmodule

bind cfg_ext_bridge cfg_ext_bridge_chk #(
  .TIMEOUT(TIMEOUT), .PF_LEG_END(PF_LEG_END), .VF_LEG_END(VF_LEG_END),
  .PF_EXT_END(PF_EXT_END), .VF_EXT_END(VF_EXT_END)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .cpl_valid(cpl_valid), .ext_req(ext_req),
  .ext_write(ext_write), .ext_is_vf(ext_is_vf), .ext_addr(ext_addr),
  .ext_rsp_valid(ext_rsp_valid)
);

// File: tb/cfg_ext_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_ext_bridge_tb_top;
  localparam int TMO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_is_vf = 1'b0;
  logic [2:0]  req_func = '0;
  logic [9:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, cpl_valid, ext_req, ext_write, ext_is_vf;
  logic [31:0] cpl_data, ext_wdata;
  logic [2:0]  ext_func;
  logic [9:0]  ext_addr;
  logic [3:0]  ext_be;
  logic        ext_rsp_valid = 1'b0;
  logic [31:0] ext_rsp_data = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_ext_bridge #(.FUNC_W(3), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_is_vf(req_is_vf), .req_func(req_func),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .cpl_valid(cpl_valid), .cpl_data(cpl_data), .ext_req(ext_req),
    .ext_write(ext_write), .ext_is_vf(ext_is_vf), .ext_func(ext_func),
    .ext_addr(ext_addr), .ext_be(ext_be), .ext_wdata(ext_wdata),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stub_exp(input bit vf, input logic [11:0] ab);
    if (ab == (vf ? 12'h050 : 12'h070)) return {16'h0000, 8'hC0, 8'h10};
    if (ab == (vf ? 12'h120 : 12'h160)) return {12'h200, 4'h1, 16'h0010};
    return {16'hC0DE, 5'b0, vf, ab[11:2]};
  endfunction

  task automatic issue(input bit wr, input bit vf, input logic [2:0] fn,
                       input logic [11:0] ab, input logic [3:0] be, input logic [31:0] wd);
    req_write = wr; req_is_vf = vf; req_func = fn; req_addr = ab[11:2];
    req_be = be; req_wdata = wd; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic int_read(input string tag, input bit vf, input logic [11:0] ab);
    issue(1'b0, vf, 3'd2, ab, 4'hF, '0);
    chk(cpl_valid === 1'b1, {tag, " cpl_valid"}, 32'(cpl_valid), 1);
    chk(cpl_data === stub_exp(vf, ab), {tag, " data"}, cpl_data, stub_exp(vf, ab));
    chk(ext_req === 1'b0, {tag, " no ext_req"}, 32'(ext_req), 0);
    @(negedge clk);
  endtask

  task automatic chk_ext(input string tag, input bit wr, input bit vf, input logic [2:0] fn,
                         input logic [11:0] ab, input logic [3:0] be, input logic [31:0] wd);
    chk(ext_req === 1'b1, {tag, " ext_req"}, 32'(ext_req), 1);
    chk(ext_write === wr && ext_is_vf === vf && ext_func === fn && ext_addr === ab[11:2],
        {tag, " ext fields"}, {17'b0, ext_write, ext_is_vf, ext_func, ext_addr},
        {17'b0, wr, vf, fn, ab[11:2]});
    if (wr) chk(ext_be === be && ext_wdata === wd, {tag, " ext wdata"}, ext_wdata, wd);
  endtask

  task automatic respond(input string tag, input int d, input logic [31:0] v);
    for (int i = 1; i < d; i++) begin
      chk(cpl_valid === 1'b0, {tag, " no early cpl"}, 32'(cpl_valid), 0);
      @(negedge clk);
    end
    ext_rsp_valid = 1'b1; ext_rsp_data = v;
    @(negedge clk);
    ext_rsp_valid = 1'b0;
    chk(cpl_valid === 1'b1 && cpl_data === v, {tag, " cpl data"}, cpl_data, v);
    @(negedge clk);
  endtask

  task automatic fwd_read(input string tag, input bit vf, input logic [2:0] fn,
                          input logic [11:0] ab, input int d, input logic [31:0] v);
    issue(1'b0, vf, fn, ab, 4'hF, '0);
    chk_ext(tag, 1'b0, vf, fn, ab, 4'hF, '0);
    chk(cpl_valid === 1'b0, {tag, " no cpl at strobe"}, 32'(cpl_valid), 0);
    respond(tag, d, v);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cpl_valid === 1'b0 && ext_req === 1'b0, "R1 outputs in reset", {30'b0, cpl_valid, ext_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(cpl_valid === 1'b0 && ext_req === 1'b0, "R1 idle after reset", {30'b0, cpl_valid, ext_req}, 0);
  endtask

  task automatic t_internal;
    int_read("R2 pf hdr", 1'b0, 12'h000);
    int_read("R2 pf leg top", 1'b0, 12'h07C);
    int_read("R2 pf ext base", 1'b0, 12'h100);
    int_read("R2 vf leg", 1'b1, 12'h05C);
  endtask

  task automatic t_nextptr;
    int_read("R5 pf leg next", 1'b0, 12'h070);
    int_read("R5 vf leg next", 1'b1, 12'h050);
    int_read("R5 pf ext next", 1'b0, 12'h160);
    int_read("R5 vf ext next", 1'b1, 12'h120);
  endtask

  task automatic t_forward;
    fwd_read("R3 R6 pf gap", 1'b0, 3'd5, 12'h080, 3, 32'hDEADBEEF);
    fwd_read("R6 pf high", 1'b0, 3'd1, 12'hFFC, 1, 32'h0000_0000);
  endtask

  task automatic t_limits;
    fwd_read("R4 vf 0x7C fwd", 1'b1, 3'd3, 12'h07C, 2, 32'h1234_5678);
    int_read("R4 vf 0x13C int", 1'b1, 12'h13C);
    fwd_read("R4 vf 0x144 fwd", 1'b1, 3'd0, 12'h144, 1, 32'hA5A5_0001);
    int_read("R4 pf 0x144 int", 1'b0, 12'h144);
  endtask

  task automatic t_writes;
    issue(1'b1, 1'b0, 3'd4, 12'h200, 4'b0011, 32'hCAFE_F00D);
    chk_ext("R3 fwd write", 1'b1, 1'b0, 3'd4, 12'h200, 4'b0011, 32'hCAFE_F00D);
    for (int i = 0; i < 3; i++) begin
      chk(cpl_valid === 1'b0, "R10 no cpl for fwd write", 32'(cpl_valid), 0);
      @(negedge clk);
    end
    issue(1'b1, 1'b0, 3'd4, 12'h004, 4'hF, 32'h0BAD_0BAD);
    chk(ext_req === 1'b0 && cpl_valid === 1'b0, "R10 internal write silent",
        {30'b0, ext_req, cpl_valid}, 0);
    @(negedge clk);
    chk(ext_req === 1'b0 && cpl_valid === 1'b0, "R10 internal write silent later",
        {30'b0, ext_req, cpl_valid}, 0);
  endtask

  task automatic t_stall;
    issue(1'b0, 1'b0, 3'd6, 12'h0C0, 4'hF, '0);
    chk_ext("R7 pending read", 1'b0, 1'b0, 3'd6, 12'h0C0, 4'hF, '0);
    req_write = 1'b0; req_is_vf = 1'b0; req_addr = 10'h000; req_valid = 1'b1;
    #1;
    chk(req_ready === 1'b0, "R7 read stalled", 32'(req_ready), 0);
    @(negedge clk);
    chk(cpl_valid === 1'b0 && ext_req === 1'b0, "R7 stalled read not taken",
        {30'b0, cpl_valid, ext_req}, 0);
    req_write = 1'b1; req_addr = 10'h0C0; req_be = 4'b1000; req_wdata = 32'h7700_0000;
    #1;
    chk(req_ready === 1'b1, "R7 write passes", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk_ext("R7 write during read", 1'b1, 1'b0, 3'd6, 12'h300, 4'b1000, 32'h7700_0000);
    respond("R7 R6 held read", 2, 32'h5151_5151);
    int_read("R7 read after release", 1'b0, 12'h008);
  endtask

  task automatic t_timeout;
    int k;
    issue(1'b0, 1'b1, 3'd7, 12'h400, 4'hF, '0);
    chk_ext("R8 tmo read", 1'b0, 1'b1, 3'd7, 12'h400, 4'hF, '0);
    k = 0;
    while (cpl_valid !== 1'b1 && k < 40) begin @(negedge clk); k++; end
    chk(k == TMO, "R8 timeout latency", 32'(k), 32'(TMO));
    chk(cpl_data === 32'h0, "R8 timeout data zero", cpl_data, 0);
    ext_rsp_valid = 1'b1; ext_rsp_data = 32'hBEEF_BEEF;
    @(negedge clk);
    ext_rsp_valid = 1'b0;
    chk(cpl_valid === 1'b0, "R9 late response dropped", 32'(cpl_valid), 0);
    @(negedge clk);
    chk(cpl_valid === 1'b0, "R9 late response dropped later", 32'(cpl_valid), 0);
    ext_rsp_valid = 1'b1; ext_rsp_data = 32'h1111_2222;
    @(negedge clk);
    ext_rsp_valid = 1'b0;
    chk(cpl_valid === 1'b0, "R9 idle response dropped", 32'(cpl_valid), 0);
    int_read("R9 R2 read after timeout", 1'b1, 12'h104);
  endtask

  initial begin
    t_reset;
    t_internal;
    t_nextptr;
    t_forward;
    t_limits;
    t_writes;
    t_stall;
    t_timeout;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule